// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Split 64-bit Accumulator

This unit keeps a 64-bit running total as two 32-bit halves, a high word and a low word. Each valid cycle carries one operation. It can add a product into the total, or subtract a product from it. It can also add a product whose second factor is a 16-bit immediate. The last operation hands out the low word and empties the total.

Every product is cut down to its low 32 bits. That 32-bit value is then sign-extended to 64 bits before it reaches the adder. A large product can therefore add nothing, or add a negative amount, even when both factors are positive.

A read-and-clear returns the low word as it stood before the clear. The whole 64-bit total becomes zero on the same edge. The read value is held in a register until the next read-and-clear. The full accumulator is also driven out so that the state can be observed.

Top module: `mac_acc64`

## Requirements
- R1: After reset is asserted, the accumulator output `acc_q` is 0 and the read value `rd_data` is 0.
- R2: Op code 2'b00 with `op_valid` high adds the sign-extended low 32 bits of `opnd_a*opnd_b` to the 64-bit accumulator. The new value appears on `acc_q` after the next rising clock edge.
- R3: Op code 2'b01 with `op_valid` high subtracts the same sign-extended 32-bit product from the accumulator.
- R4: Op code 2'b10 with `op_valid` high sign-extends `imm16` to 32 bits and multiplies it by `opnd_a`. The truncated, sign-extended product is added to the accumulator, and `opnd_b` has no effect. `imm16` has no effect on op codes 2'b00 and 2'b01.
- R5: Only product bits 31..0 count, and bit 31 sets the sign. For example, 0x10000*0x10000 adds 0, and 0x8000*0x10000 adds 0xFFFF_FFFF_8000_0000.
- R6: Op code 2'b11 with `op_valid` high loads `rd_data` with the low accumulator word from before that edge. On the same edge it sets all 64 accumulator bits to 0, and the operands have no effect.
- R7: With `op_valid` low, the accumulator and `rd_data` keep their values, whatever the op code and operands are.
- R8: `rd_data` changes only on a valid read-and-clear. Accumulate and subtract operations leave it unchanged.
- R9: The accumulator wraps modulo 2^64. A carry out of the low word goes into the high word, and a borrow is taken from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe that qualifies the op code for this cycle |
| op_code | input | 2 | 00 accumulate, 01 subtract, 10 accumulate with immediate, 11 read-and-clear |
| opnd_a | input | 32 | First factor |
| opnd_b | input | 32 | Second factor for the register forms |
| imm16 | input | 16 | Signed immediate factor for op code 10 |
| rd_data | output | 32 | Low word captured by the last read-and-clear |
| acc_q | output | 64 | Current accumulator, high word in bits 63..32 |

## Verification
The assertions assume that `op_code` and the operands are known (no X or Z) whenever `op_valid` is high. They also assume that `op_valid` stays low while reset is active.

The stimulus changes inputs only on the falling clock edge. It holds `op_valid` low throughout reset, and it drives the operands to defined values in every cycle, including the idle cycles used to test holding.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MOP_ACC   = 2'b00,
    MOP_SUB   = 2'b01,
    MOP_ACCI  = 2'b10,
    MOP_RDCLR = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_product.sv
module mac_product
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  mac_op_e             op,
  input  logic [DATA_W-1:0]   fac_a,
  input  logic [DATA_W-1:0]   fac_b,
  input  logic [IMM_W-1:0]    imm,
  output logic [ACC_W-1:0]    prod_ext
);
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] sel_b;
  logic [DATA_W-1:0] prod_lo;

  generate
    if (IMM_W < DATA_W) begin : g_imm_widen
      assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_imm_cut
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    sel_b    = (op == MOP_ACCI) ? imm_ext : fac_b;
    prod_lo  = fac_a * sel_b;
    prod_ext = {{DATA_W{prod_lo[DATA_W-1]}}, prod_lo};
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  mac_op_e            op,
  input  logic [ACC_W-1:0]   prod_ext,
  output logic [ACC_W-1:0]   acc_q,
  output logic [DATA_W-1:0]  rd_q
);
  logic [DATA_W-1:0] hi_q, lo_q;
  logic [ACC_W-1:0]  acc_cur, acc_d;
  logic              acc_en;
  logic [DATA_W-1:0] rd_d;
  logic              rd_en;

  assign acc_cur = {hi_q, lo_q};

  always_comb begin
    acc_d  = acc_cur;
    acc_en = 1'b0;
    rd_d   = rd_q;
    rd_en  = 1'b0;
    if (valid) begin
      acc_en = 1'b1;
      unique case (op)
        MOP_ACC, MOP_ACCI: acc_d = acc_cur + prod_ext;
        MOP_SUB:           acc_d = acc_cur - prod_ext;
        MOP_RDCLR: begin
          acc_d = '0;
          rd_d  = lo_q;
          rd_en = 1'b1;
        end
        default:           acc_d = acc_cur;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (acc_en) begin
      hi_q <= acc_d[ACC_W-1:DATA_W];
      lo_q <= acc_d[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign acc_q = acc_cur;
endmodule

// File: rtl/mac_acc64.sv
module mac_acc64
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [1:0]         op_code,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  input  logic [IMM_W-1:0]   imm16,
  output logic [DATA_W-1:0]  rd_data,
  output logic [ACC_W-1:0]   acc_q
);
  mac_op_e          op;
  logic [ACC_W-1:0] prod_ext;

  assign op = mac_op_e'(op_code);

  mac_product #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_prod (
    .op       (op),
    .fac_a    (opnd_a),
    .fac_b    (opnd_b),
    .imm      (imm16),
    .prod_ext (prod_ext)
  );

  mac_accum #(.DATA_W(DATA_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (op_valid),
    .op       (op),
    .prod_ext (prod_ext),
    .acc_q    (acc_q),
    .rd_q     (rd_data)
  );
endmodule

// File: rtl/mac_acc64_chk.sv
module mac_acc64_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic [1:0]         op_code,
  input logic [DATA_W-1:0]  opnd_a,
  input logic [DATA_W-1:0]  opnd_b,
  input logic [IMM_W-1:0]   imm16,
  input logic [DATA_W-1:0]  rd_data,
  input logic [ACC_W-1:0]   acc_q
);
  logic [DATA_W-1:0] ref_rr, ref_ri;
  logic [ACC_W-1:0]  ref_rr_x, ref_ri_x;

  always_comb begin
    ref_rr   = opnd_a * opnd_b;
    ref_ri   = opnd_a * DATA_W'($signed(imm16));
    ref_rr_x = ACC_W'($signed(ref_rr));
    ref_ri_x = ACC_W'($signed(ref_ri));
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (acc_q == '0 && rd_data == '0);
    end
  end

  assert_acc_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'b00) |=> acc_q == $past(acc_q) + $past(ref_rr_x));

  assert_acc_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'b01) |=> acc_q == $past(acc_q) - $past(ref_rr_x));

  assert_acc_imm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'b10) |=> acc_q == $past(acc_q) + $past(ref_ri_x));

  assert_rdclr_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'b11) |=> (rd_data == $past(acc_q[DATA_W-1:0]) && acc_q == '0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_q) && $stable(rd_data)));

  assert_rd_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != 2'b11) |=> $stable(rd_data));
endmodule

bind mac_acc64 mac_acc64_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .imm16    (imm16),
  .rd_data  (rd_data),
  .acc_q    (acc_q)
);

// File: tb/mac_acc64_tb.sv
module mac_acc64_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_code;
  logic [31:0] opnd_a, opnd_b;
  logic [15:0] imm16;
  logic [31:0] rd_data;
  logic [63:0] acc_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mac_acc64 u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16),
    .rd_data(rd_data), .acc_q(acc_q)
  );

  task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, result sampled at next falling edge
  task automatic step(logic v, logic [1:0] op, logic [31:0] a, logic [31:0] b, logic [15:0] im);
    @(negedge clk);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b; imm16 = im;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic clear_acc();
    step(1'b1, 2'b11, 32'h0, 32'h0, 16'h0);
  endtask

  task automatic t_reset_R1();
    chk64("R1 acc", acc_q, 64'h0);
    chk64("R1 rd", {32'h0, rd_data}, 64'h0);
  endtask

  task automatic t_mac_R2();
    clear_acc();
    step(1'b1, 2'b00, 32'd3, 32'd4, 16'h7777);
    chk64("R2 3*4", acc_q, 64'd12);
    step(1'b1, 2'b00, 32'hFFFF_FFFE, 32'd5, 16'h0);
    chk64("R2 -2*5", acc_q, 64'd2);
  endtask

  task automatic t_msb_R3();
    clear_acc();
    step(1'b1, 2'b01, 32'd7, 32'd6, 16'h1234);
    chk64("R3 0-42", acc_q, 64'hFFFF_FFFF_FFFF_FFD6);
    step(1'b1, 2'b01, 32'hFFFF_FFFF, 32'd42, 16'h0);
    chk64("R3 -42-(-42)", acc_q, 64'h0);
  endtask

  task automatic t_maci_R4();
    clear_acc();
    step(1'b1, 2'b10, 32'd1000, 32'hDEAD_BEEF, 16'hFFFE);
    chk64("R4 1000*-2", acc_q, 64'hFFFF_FFFF_FFFF_F830);
    step(1'b1, 2'b10, 32'd3, 32'h0000_0100, 16'h0010);
    chk64("R4 3*16", acc_q, 64'hFFFF_FFFF_FFFF_F860);
  endtask

  task automatic t_trunc_R5();
    clear_acc();
    step(1'b1, 2'b00, 32'h0001_0000, 32'h0001_0000, 16'h0);
    chk64("R5 zero low word", acc_q, 64'h0);
    step(1'b1, 2'b00, 32'h0000_8000, 32'h0001_0000, 16'h0);
    chk64("R5 bit31 extends", acc_q, 64'hFFFF_FFFF_8000_0000);
  endtask

  task automatic t_rdclr_R6();
    clear_acc();
    step(1'b1, 2'b00, 32'h1234_5678, 32'd1, 16'h0);
    step(1'b1, 2'b00, 32'h8000_0000, 32'd1, 16'h0);
    chk64("R6 pre", acc_q, 64'hFFFF_FFFF_9234_5678);
    step(1'b1, 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF);
    chk64("R6 rd low word", {32'h0, rd_data}, 64'h0000_0000_9234_5678);
    chk64("R6 acc zero", acc_q, 64'h0);
  endtask

  task automatic t_hold_R7_R8();
    clear_acc();
    step(1'b1, 2'b00, 32'd9, 32'd9, 16'h0);
    step(1'b1, 2'b11, 32'h0, 32'h0, 16'h0);
    chk64("R8 rd after read", {32'h0, rd_data}, 64'd81);
    step(1'b1, 2'b00, 32'd5, 32'd5, 16'h0);
    chk64("R8 rd kept on acc", {32'h0, rd_data}, 64'd81);
    step(1'b0, 2'b00, 32'd7, 32'd7, 16'h0);
    chk64("R7 idle acc", acc_q, 64'd25);
    step(1'b0, 2'b11, 32'd0, 32'd0, 16'h0);
    chk64("R7 idle rdclr acc", acc_q, 64'd25);
    chk64("R7 idle rdclr rd", {32'h0, rd_data}, 64'd81);
  endtask

  task automatic t_wrap_R9();
    clear_acc();
    step(1'b1, 2'b00, 32'h7FFF_FFFF, 32'd1, 16'h0);
    step(1'b1, 2'b00, 32'h7FFF_FFFF, 32'd1, 16'h0);
    chk64("R9 no carry", acc_q, 64'h0000_0000_FFFF_FFFE);
    step(1'b1, 2'b00, 32'd2, 32'd1, 16'h0);
    chk64("R9 carry to high", acc_q, 64'h0000_0001_0000_0000);
    step(1'b1, 2'b01, 32'd1, 32'd1, 16'h0);
    chk64("R9 borrow from high", acc_q, 64'h0000_0000_FFFF_FFFF);
    clear_acc();
    step(1'b1, 2'b01, 32'd1, 32'd1, 16'h0);
    chk64("R9 wrap below zero", acc_q, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1'b1, 2'b00, 32'd1, 32'd1, 16'h0);
    chk64("R9 wrap above max", acc_q, 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 2'b00;
    opnd_a = '0; opnd_b = '0; imm16 = '0;
    repeat (3) @(negedge clk);
    t_reset_R1();
    rst_n = 1'b1;
    t_mac_R2();
    t_msb_R3();
    t_maci_R4();
    t_trunc_R5();
    t_rdclr_R6();
    t_hold_R7_R8();
    t_wrap_R9();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule